// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is a two-wire serial slave. It gives a host controller read and write access to eight 8-bit configuration registers inside a clock generator. A fast system clock oversamples the serial clock and data lines. The block pulls the data line low through an open-drain enable. It also decodes a few live control bits for the rest of the chip: output enable, spread enable, spread depth, test-mode entry and test-output select.

The host addresses the device as 7-bit address 1101001 (D2h as a write byte). It then sends a command byte, which picks one of two modes:

- **Single-register mode** touches one register chosen by an offset field.
- **Block mode** begins with a byte-count byte in either direction and walks the registers upward from register 0.

A read of either kind opens with a write phase that carries the command. A repeated START then follows, and the address is sent again with the read bit set. The registers load fixed values at reset, so the host never has to configure the block.

Top module: `clkgen_cfg_smbus`

## Requirements
- R1: After reset the eight registers hold 7Ch, 00h, EAh, AFh, 01h, 00h, 13h, 01h for indices 0 to 7, and the data-line enable is inactive.
- R2: Only address 1101001 is acknowledged. After any other address the block gives no ACK and ignores every following byte until the next START.
- R3: Single-register write: the host sends address+W, then a command, then one data byte, and the slave ACKs each byte. The command has bit 7 = 1, bits 6:5 = 00 and bits 4:0 = the register index. The data byte, sent MSB first, lands in that register.
- R4: Single-register read: the host sends address+W, the command, a repeated START and address+R. The slave returns the indexed register, and the host finishes with a NACK and a STOP.
- R5: Block write: the command is 00h, followed by a byte-count byte and then data bytes. The data bytes fill registers 0, 1, 2 and upward in that order. Every byte is ACKed, and the host may STOP after any complete byte.
- R6: Block read: the command is 00h, followed by a repeated START and address+R. The slave first returns the count 08h, then registers 0, 1, 2 and upward until the host NACKs. After an early NACK, the next transaction works normally.
- R7: The command is still ACKed, but no register changes, in any of these cases:
  - command bits 6:5 are not 00;
  - a single-register index is above 7;
  - a block command has a nonzero offset.
- R8: Register 7 is read-only and always returns 01h.
- R9: The decoded outputs follow the registers in the same cycle the register is written:
  - output enable = register 0 bit 2;
  - spread enable = register 2 bit 2;
  - spread depth = register 2 bit 7 (1 = deeper spread);
  - test-output select = register 6 bit 7;
  - test-mode entry = register 6 bit 6.
- R10: The slave changes its data-line enable only while the serial clock is low. It drives the line low for the whole ACK slot of every byte it accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls the data line low |
| out_en_o | output | 1 | Clock output enable (0 = high impedance) |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_deep_o | output | 1 | Spread depth: 0 = -0.35 %, 1 = -0.5 % |
| test_mode_o | output | 1 | Test clock mode entry |
| test_sel_o | output | 1 | Test output: 0 = high impedance, 1 = reference divided |

## Verification
A register write and the start of the ACK for that data byte happen on the same system-clock cycle, the one that follows the serial-clock fall closing bit 8. The decoded control outputs therefore change together with the ACK. The bench provokes this by writing 00h to register 0 while the output enable is high. During bit 8 it samples the output enable, which must still be 1. In the ACK slot it samples the data line, which must be low, and the output enable, which must now be 0.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    SG_ADDR,
    SG_CMD,
    SG_COUNT,
    SG_DATA
  } stage_e;

  localparam int OFF_W = 5;

  // control bit locations decoded outside the bank
  localparam int OE_REG     = 0;
  localparam int OE_BIT     = 2;
  localparam int SPR_REG    = 2;
  localparam int SPR_EN_BIT = 2;
  localparam int SPR_DP_BIT = 7;
  localparam int TST_REG    = 6;
  localparam int TST_SL_BIT = 7;
  localparam int TST_MD_BIT = 6;

  function automatic logic [7:0] reset_val(input int idx);
    case (idx)
      0:       return 8'h7C;
      1:       return 8'h00;
      2:       return 8'hEA;
      3:       return 8'hAF;
      4:       return 8'h01;
      5:       return 8'h00;
      6:       return 8'h13;
      7:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter  int NUM_REGS = 8,
  parameter  int DW       = 8,
  parameter  int RO_IDX   = 7,
  localparam int AW       = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                waddr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [AW-1:0]                raddr_i,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_REGS-1:0][DW-1:0]  regs_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == RO_IDX) begin : g_ro
      assign regs_o[i] = DW'(reset_val(i));
    end else begin : g_rw
      logic [DW-1:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            val_q <= DW'(reset_val(i));
        else if (we_i && waddr_i == AW'(i))     val_q <= wdata_i;
      end
      assign regs_o[i] = val_q;
    end
  end

  assign rdata_o = regs_o[raddr_i];

  assert_write_lands_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (waddr_i != AW'(RO_IDX)) |=> regs_o[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter  logic [6:0] DEV_ADDR = 7'h69,
  parameter  int         NUM_REGS = 8,
  parameter  int         DW       = 8,
  localparam int         AW       = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          sda_oe_o
);

  localparam logic [OFF_W-1:0] NREG = OFF_W'(NUM_REGS);
  localparam logic [3:0]       LAST = 4'd8;

  phase_e           phase_q;
  stage_e           stage_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic [7:0]       cmd_q;
  logic [OFF_W-1:0] ptr_q;
  logic             cnt_pend_q;
  logic             go_tx_q;
  logic [DW-1:0]    tx_q;
  logic             oe_q;

  logic             access_ok;
  logic             ptr_in;
  logic [DW-1:0]    tx_next;
  logic             byte_done;

  assign ptr_in    = ptr_q < NREG;
  assign access_ok = (cmd_q[6:5] == 2'b00) && (cmd_q[7] || cmd_q[4:0] == '0);
  assign tx_next   = cnt_pend_q ? DW'(NUM_REGS) : (ptr_in ? rdata_i : '0);
  assign byte_done = scl_fall_i && bit_cnt_q == LAST;

  assign raddr_o  = ptr_q[AW-1:0];
  assign waddr_o  = ptr_q[AW-1:0];
  assign wdata_o  = shreg_q[DW-1:0];
  assign we_o     = phase_q == PH_RX && stage_q == SG_DATA && byte_done && access_ok && ptr_in;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      stage_q    <= SG_ADDR;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      cmd_q      <= '0;
      ptr_q      <= '0;
      cnt_pend_q <= 1'b0;
      go_tx_q    <= 1'b0;
      tx_q       <= '0;
      oe_q       <= 1'b0;
    end else if (start_i) begin
      phase_q   <= PH_RX;
      stage_q   <= SG_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise_i && bit_cnt_q < LAST) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            unique case (stage_q)
              SG_ADDR: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  phase_q <= PH_RX_ACK;
                  go_tx_q <= shreg_q[0];
                  if (shreg_q[0]) begin
                    cnt_pend_q <= ~cmd_q[7];
                    ptr_q      <= cmd_q[7] ? cmd_q[4:0] : '0;
                  end else begin
                    stage_q <= SG_CMD;
                  end
                end else begin
                  phase_q <= PH_SKIP;
                end
              end
              SG_CMD: begin
                cmd_q   <= shreg_q;
                oe_q    <= 1'b1;
                phase_q <= PH_RX_ACK;
                go_tx_q <= 1'b0;
                ptr_q   <= shreg_q[7] ? shreg_q[4:0] : '0;
                stage_q <= shreg_q[7] ? SG_DATA : SG_COUNT;
              end
              SG_COUNT: begin
                oe_q    <= 1'b1;
                phase_q <= PH_RX_ACK;
                stage_q <= SG_DATA;
              end
              default: begin
                oe_q    <= 1'b1;
                phase_q <= PH_RX_ACK;
                if (ptr_in) ptr_q <= ptr_q + 1'b1;
              end
            endcase
          end
        end
        PH_RX_ACK, PH_TX_ACK: begin
          if (phase_q == PH_TX_ACK && scl_rise_i && sda_i) begin
            phase_q <= PH_SKIP;
          end else if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (phase_q == PH_TX_ACK || go_tx_q) begin
              phase_q <= PH_TX;
              tx_q    <= tx_next;
              oe_q    <= ~tx_next[DW-1];
              if (cnt_pend_q)  cnt_pend_q <= 1'b0;
              else if (ptr_in) ptr_q      <= ptr_q + 1'b1;
            end else begin
              phase_q <= PH_RX;
              oe_q    <= 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bit_cnt_q == LAST) begin
              oe_q    <= 1'b0;
              phase_q <= PH_TX_ACK;
            end else begin
              tx_q <= {tx_q[DW-2:0], 1'b0};
              oe_q <= ~tx_q[DW-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_oe_scl_low_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) && !$past(start_i || stop_i) |-> !$past(scl_i));

  assert_ack_slot_driven_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_RX_ACK |-> sda_oe_o);

  assert_skip_silent_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_SKIP |-> !sda_oe_o);

  assert_write_cs_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> cmd_q[6:5] == 2'b00);

endmodule

// File: rtl/clkgen_cfg_smbus.sv
module clkgen_cfg_smbus
  import smb_pkg::*;
#(
  parameter  logic [6:0] DEV_ADDR    = 7'h69,
  parameter  int         NUM_REGS    = 8,
  parameter  int         DW          = 8,
  parameter  int         RO_IDX      = 7,
  parameter  int         SYNC_STAGES = 2,
  localparam int         AW          = $clog2(NUM_REGS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic out_en_o,
  output logic spread_en_o,
  output logic spread_deep_o,
  output logic test_mode_o,
  output logic test_sel_o
);

  logic                        scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic                        we;
  logic [AW-1:0]               waddr, raddr;
  logic [DW-1:0]               wdata, rdata;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  smb_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .DW(DW)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS), .DW(DW), .RO_IDX(RO_IDX)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .regs_o  (regs)
  );

  assign out_en_o      = regs[OE_REG][OE_BIT];
  assign spread_en_o   = regs[SPR_REG][SPR_EN_BIT];
  assign spread_deep_o = regs[SPR_REG][SPR_DP_BIT];
  assign test_sel_o    = regs[TST_REG][TST_SL_BIT];
  assign test_mode_o   = regs[TST_REG][TST_MD_BIT];

endmodule

// File: tb/clkgen_cfg_smbus_test.sv
module clkgen_cfg_smbus_test;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, out_en, spread_en, spread_deep, test_mode, test_sel;

  always #10 clk = ~clk;

  assign sda_bus = host_sda & ~sda_oe;

  clkgen_cfg_smbus uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .scl_i         (host_scl),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .out_en_o      (out_en),
    .spread_en_o   (spread_en),
    .spread_deep_o (spread_deep),
    .test_mode_o   (test_mode),
    .test_sel_o    (test_sel)
  );

  int checks = 0;
  int fails = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_reg [8];
  logic oe_at_bit8, oe_at_ack;

  // {write cmd, write data, read cmd, expected readback}
  localparam logic [31:0] VEC [10] = '{
    32'h80_55_80_55, 32'h81_A3_81_A3, 32'h83_3C_83_3C, 32'h84_00_84_00,
    32'h85_FF_85_FF, 32'h86_C0_86_C0, 32'h87_FF_87_01, 32'hA1_99_81_A3,
    32'h88_77_80_55, 32'hC3_12_83_3C
  };

  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && host_scl) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; host_scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    host_sda = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(Q);
      host_scl = 1'b1; wq(Q);
      if (i == 0) oe_at_bit8 = out_en;
      wq(Q);
      host_scl = 1'b0; wq(Q);
    end
    host_sda = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    ack = sda_bus;
    oe_at_ack = out_en;
    wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      host_scl = 1'b1; wq(Q);
      b[i] = sda_bus;
      wq(Q);
      host_scl = 1'b0; wq(Q);
    end
    host_sda = nack; wq(Q);
    host_scl = 1'b1; wq(2*Q);
    host_scl = 1'b0; wq(Q);
    host_sda = 1'b1;
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] data, input string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk(req, {7'd0, a}, 8'h00);
    send_byte(cmd, a);   chk(req, {7'd0, a}, 8'h00);
    send_byte(data, a);  chk(req, {7'd0, a}, 8'h00);
    bus_stop();
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk(req, {7'd0, a}, 8'h00);
    send_byte(cmd, a);   chk(req, {7'd0, a}, 8'h00);
    bus_rstart();
    send_byte(8'hD3, a); chk(req, {7'd0, a}, 8'h00);
    recv_byte(d, 1'b1);
    bus_stop();
  endtask

  task automatic block_read(input int n, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); chk(req, {7'd0, a}, 8'h00);
    send_byte(8'h00, a); chk(req, {7'd0, a}, 8'h00);
    bus_rstart();
    send_byte(8'hD3, a); chk(req, {7'd0, a}, 8'h00);
    recv_byte(d, 1'b0);  chk("R6 count", d, 8'h08);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i == n - 1);
      chk(req, d, exp_reg[i]);
    end
    bus_stop();
  endtask

  task automatic block_write(input logic [7:0] cmd, input int n, input logic [63:0] data,
                             input string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a);     chk(req, {7'd0, a}, 8'h00);
    send_byte(cmd, a);       chk(req, {7'd0, a}, 8'h00);
    send_byte(8'(n), a);     chk(req, {7'd0, a}, 8'h00);
    for (int i = 0; i < n; i++) begin
      send_byte(data[63-8*i -: 8], a); chk(req, {7'd0, a}, 8'h00);
      if (cmd == 8'h00 && i < 7) exp_reg[i] = data[63-8*i -: 8];
    end
    bus_stop();
  endtask

  task automatic chk_decode(input string req);
    chk(req, {7'd0, out_en},      {7'd0, exp_reg[0][2]});
    chk(req, {7'd0, spread_en},   {7'd0, exp_reg[2][2]});
    chk(req, {7'd0, spread_deep}, {7'd0, exp_reg[2][7]});
    chk(req, {7'd0, test_sel},    {7'd0, exp_reg[6][7]});
    chk(req, {7'd0, test_mode},   {7'd0, exp_reg[6][6]});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=complete");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic a;
    exp_reg = '{8'h7C, 8'h00, 8'hEA, 8'hAF, 8'h01, 8'h00, 8'h13, 8'h01};
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R1 reset state, R9 decode of reset values
    chk("R1 oe idle", {7'd0, sda_oe}, 8'h00);
    chk_decode("R1 R9 reset decode");
    block_read(8, "R1 R6 reset contents");

    // vector table: single-register write then read (R3 R4 R7 R8)
    foreach (VEC[k]) begin
      logic [7:0] wc, wd, rc, ex;
      {wc, wd, rc, ex} = VEC[k];
      byte_write(wc, wd, "R3 write ack");
      byte_read(rc, d, "R4 read ack");
      chk("R4 R7 R8 readback", d, ex);
      if (wc[7] && wc[6:5] == 2'b00 && wc[4:0] < 5'd7) exp_reg[wc[2:0]] = wd;
    end
    chk_decode("R9 decode after table");

    // same-cycle write and ACK: out_en falls inside the ACK slot (R9 R10)
    bus_start();
    send_byte(8'hD2, a); chk("R3 addr ack", {7'd0, a}, 8'h00);
    send_byte(8'h80, a); chk("R3 cmd ack", {7'd0, a}, 8'h00);
    send_byte(8'h00, a);
    chk("R10 data ack", {7'd0, a}, 8'h00);
    chk("R9 out_en before ack", {7'd0, oe_at_bit8}, 8'h01);
    chk("R9 out_en at ack", {7'd0, oe_at_ack}, 8'h00);
    bus_stop();
    exp_reg[0] = 8'h00;

    // R2 wrong address: no ACK and later bytes ignored
    bus_start();
    send_byte(8'hD4, a); chk("R2 addr nack", {7'd0, a}, 8'h01);
    send_byte(8'h81, a); chk("R2 cmd ignored", {7'd0, a}, 8'h01);
    send_byte(8'hAA, a); chk("R2 data ignored", {7'd0, a}, 8'h01);
    bus_stop();
    byte_read(8'h81, d, "R2 read ack");
    chk("R2 reg unchanged", d, 8'hA3);

    // R5 partial block write, then full block read R6
    block_write(8'h00, 3, 64'h11_22_33_00_00_00_00_00, "R5 block ack");
    block_read(8, "R5 R6 block contents");
    chk_decode("R9 decode after block");

    // R7 block command with nonzero offset is suppressed
    block_write(8'h02, 1, 64'h5A_00_00_00_00_00_00_00, "R7 ack");
    byte_read(8'h80, d, "R7 read ack");
    chk("R7 block offset suppressed", d, 8'h11);

    // R8 full block write cannot alter register 7
    block_write(8'h00, 8, 64'h04_00_84_10_20_30_40_FF, "R5 full block ack");
    block_read(8, "R8 R6 after full write");
    chk_decode("R9 decode after full write");

    // R6 early NACK, following transaction works
    block_read(1, "R6 early nack");
    byte_read(8'h82, d, "R6 follow ack");
    chk("R6 follow read", d, 8'h84);

    wq(10);
    chk("R10 sda changes only scl low", 8'(viol), 8'h00);
    finish_run();
  end

endmodule